// File: doc/BRIEF.md
# Gated Down-Counter with Sticky Status Flags

This block counts input pulses while an enable gate is held high. Each rising gate edge loads a signed preset. Every pulse seen while the gate stays high lowers the count by one. The count is kept as a magnitude plus a separate sign bit. The magnitude is bounded by a parameter limit, 9999 by default. When the gate falls, the running count is copied into a final-value register, together with that value's sign and out-of-range state.

A set of status flags describes what has happened. Some flags are plain mirrors of state. Others are sticky and report each event once. Sticky flags are cleared by a status-read strobe, by the next rising gate edge, or by an interrupt-request read, depending on the flag. Two events can request an interrupt:

- the live count running past the negative limit;
- a final value being replaced before it was read.

Each of these has its own enable, and the interrupt output is the OR of the pending bits. A final-read strobe marks the stored final value as consumed.

Top module: `gated_event_counter`

## Requirements
- R1: After reset every flag, every interrupt bit, both magnitudes and both sign bits are 0.
- R2: `active_o` equals the gate level sampled at the previous clock edge.
- R3: On the edge where the gate is first seen high, the preset is loaded. The magnitude is clamped to LIMIT, and a negative zero becomes +0. Each later cycle with the gate still high and `pulse_i` high lowers the count by one. While the gate is low, pulses leave the live value unchanged.
- R4: The sign bit is 1 for a negative value and 0 otherwise. Lowering +0 gives magnitude 1 with the sign bit set.
- R5: `trig_o` sets on the first counted pulse after a rising gate edge and clears on `status_rd_i`.
- R6: `zero_o` sets when a counted pulse leaves a value of 0 or below. It clears on the next rising gate edge, and a status read does not clear it.
- R7: A counted pulse at -LIMIT keeps the value at -LIMIT and sets `live_ovf_o`.
- R8: `live_ovf_o` clears on `status_rd_i`. It also clears on `irq_rd_i`, but only when its interrupt bit `irq_ovf_o` was pending.
- R9: When the gate falls, the live magnitude, sign and out-of-range state (whether saturation occurred since the load) are copied to the final outputs, and `stored_o` sets. `stored_o` clears on `status_rd_i`.
- R10: If the gate falls while the previous final value is unread, `overwrite_o` sets. A `final_rd_i` in an earlier cycle or the same cycle marks the value as read. `overwrite_o` clears on `status_rd_i`.
- R11: An overflow event sets `irq_ovf_o` only when `irq_ovf_en_i` is high. An overwrite event sets `irq_ovw_o` only when `irq_ovw_en_i` is high. `irq_o` is their OR, and `irq_rd_i` clears both.
- R12: If a set event and a clearing strobe fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Counting gate |
| pulse_i | input | 1 | Count pulse, one per cycle at most |
| preset_mag_i | input | MAG_W | Preset magnitude loaded on gate rise |
| preset_neg_i | input | 1 | Preset sign, 1 = negative |
| status_rd_i | input | 1 | Status read strobe |
| final_rd_i | input | 1 | Final value read strobe |
| irq_rd_i | input | 1 | Interrupt request read strobe |
| irq_ovf_en_i | input | 1 | Enable for the overflow interrupt |
| irq_ovw_en_i | input | 1 | Enable for the overwrite interrupt |
| live_mag_o | output | MAG_W | Live count magnitude |
| live_neg_o | output | 1 | Live count sign |
| final_mag_o | output | MAG_W | Final value magnitude |
| final_neg_o | output | 1 | Final value sign |
| final_oor_o | output | 1 | Final value out of range |
| active_o | output | 1 | Gate active |
| trig_o | output | 1 | Counting started |
| zero_o | output | 1 | Count reached zero or below |
| live_ovf_o | output | 1 | Live value overflow |
| stored_o | output | 1 | Final value stored |
| overwrite_o | output | 1 | Unread final value overwritten |
| irq_ovf_o | output | 1 | Pending overflow interrupt |
| irq_ovw_o | output | 1 | Pending overwrite interrupt |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the following:

- the magnitude stays within the limit;
- a falling gate always leaves the stored flag set, even against a same-cycle status read;
- a rising gate always clears the zero flag;
- an unread final value that is replaced always raises the overwrite flag;
- the final value holds between falling edges;
- a new overflow interrupt is always accompanied by the overflow flag.

Only the bench's scenarios can show that the arithmetic is correct. It sweeps presets across the signed range against pulse counts up to past saturation, and checks the value, the sign crossing at zero, the clamp at the negative limit and the latched final value. The bench also covers which strobe clears which flag, and that the interrupt enables gate the pending bits.

// File: rtl/gated_event_counter.sv
module gated_event_counter #(
  parameter int MAG_W = 14,
  parameter int LIMIT = 9999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             pulse_i,
  input  logic [MAG_W-1:0] preset_mag_i,
  input  logic             preset_neg_i,
  input  logic             status_rd_i,
  input  logic             final_rd_i,
  input  logic             irq_rd_i,
  input  logic             irq_ovf_en_i,
  input  logic             irq_ovw_en_i,
  output logic [MAG_W-1:0] live_mag_o,
  output logic             live_neg_o,
  output logic [MAG_W-1:0] final_mag_o,
  output logic             final_neg_o,
  output logic             final_oor_o,
  output logic             active_o,
  output logic             trig_o,
  output logic             zero_o,
  output logic             live_ovf_o,
  output logic             stored_o,
  output logic             overwrite_o,
  output logic             irq_ovf_o,
  output logic             irq_ovw_o,
  output logic             irq_o
);

  localparam logic [MAG_W-1:0] LIM = MAG_W'(LIMIT);

  logic             gate_q, arm_q, sat_q, unread_q;
  logic [MAG_W-1:0] mag_q, nxt_mag, load_mag;
  logic             neg_q, nxt_neg, load_neg, sat_hit;

  wire rise    = gate_i & ~gate_q;
  wire fall    = ~gate_i & gate_q;
  wire cnt_en  = gate_i & gate_q & pulse_i;
  wire ovf_evt = cnt_en & sat_hit;
  wire ovw_evt = fall & unread_q & ~final_rd_i;
  wire zero_hit = cnt_en & (nxt_neg | (nxt_mag == '0));

  assign load_mag = (preset_mag_i > LIM) ? LIM : preset_mag_i;
  assign load_neg = preset_neg_i & (preset_mag_i != '0);

  always_comb begin
    nxt_mag = mag_q;
    nxt_neg = neg_q;
    sat_hit = 1'b0;
    if (neg_q) begin
      if (mag_q >= LIM) sat_hit = 1'b1;
      else              nxt_mag = mag_q + 1'b1;
    end else if (mag_q == '0) begin
      nxt_neg = 1'b1;
      nxt_mag = MAG_W'(1);
    end else begin
      nxt_mag = mag_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      mag_q  <= '0;
      neg_q  <= 1'b0;
      sat_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (rise) begin
        mag_q <= load_mag;
        neg_q <= load_neg;
        sat_q <= 1'b0;
        arm_q <= 1'b1;
      end else if (cnt_en) begin
        mag_q <= nxt_mag;
        neg_q <= nxt_neg;
        arm_q <= 1'b0;
        if (sat_hit) sat_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      final_mag_o <= '0;
      final_neg_o <= 1'b0;
      final_oor_o <= 1'b0;
      unread_q    <= 1'b0;
    end else begin
      if (fall) begin
        final_mag_o <= mag_q;
        final_neg_o <= neg_q;
        final_oor_o <= sat_q;
      end
      unread_q <= fall | (unread_q & ~final_rd_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_o      <= 1'b0;
      zero_o      <= 1'b0;
      live_ovf_o  <= 1'b0;
      stored_o    <= 1'b0;
      overwrite_o <= 1'b0;
      irq_ovf_o   <= 1'b0;
      irq_ovw_o   <= 1'b0;
    end else begin
      trig_o      <= (cnt_en & arm_q) | (trig_o & ~status_rd_i);
      zero_o      <= rise ? 1'b0 : (zero_hit | zero_o);
      live_ovf_o  <= ovf_evt | (live_ovf_o & ~status_rd_i & ~(irq_rd_i & irq_ovf_o));
      stored_o    <= fall | (stored_o & ~status_rd_i);
      overwrite_o <= ovw_evt | (overwrite_o & ~status_rd_i);
      irq_ovf_o   <= (ovf_evt & irq_ovf_en_i) | (irq_ovf_o & ~irq_rd_i);
      irq_ovw_o   <= (ovw_evt & irq_ovw_en_i) | (irq_ovw_o & ~irq_rd_i);
    end
  end

  assign live_mag_o = mag_q;
  assign live_neg_o = neg_q;
  assign active_o   = gate_q;
  assign irq_o      = irq_ovf_o | irq_ovw_o;

  p_mag_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_mag_o <= LIM);
  p_zero_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && !active_o) |=> !zero_o);
  p_store_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i && active_o) |=> stored_o);
  p_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i && active_o && unread_q && !final_rd_i) |=> overwrite_o);
  p_final_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!gate_i && active_o) |=> ($stable(final_mag_o) && $stable(final_neg_o)));
  p_irq_with_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf_o) |-> live_ovf_o);
  p_trig_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> active_o);

endmodule

// File: tb/tb_gated_event_counter.sv
`timescale 1ns/1ps
module tb_gated_event_counter;
  localparam int MW = 5;
  localparam int LIM = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gate_i = 0, pulse_i = 0, preset_neg_i = 0;
  logic [MW-1:0] preset_mag_i = '0;
  logic status_rd_i = 0, final_rd_i = 0, irq_rd_i = 0;
  logic irq_ovf_en_i = 0, irq_ovw_en_i = 0;
  logic [MW-1:0] live_mag_o, final_mag_o;
  logic live_neg_o, final_neg_o, final_oor_o, active_o, trig_o, zero_o;
  logic live_ovf_o, stored_o, overwrite_o, irq_ovf_o, irq_ovw_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  gated_event_counter #(.MAG_W(MW), .LIMIT(LIM)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int sval(logic neg, logic [MW-1:0] m);
    return neg ? -int'(m) : int'(m);
  endfunction

  task automatic clear_all();
    status_rd_i = 1; final_rd_i = 1; irq_rd_i = 1;
    tick();
    status_rd_i = 0; final_rd_i = 0; irq_rd_i = 0;
  endtask

  task automatic run(int p, int n);
    int raw, v;
    bit sat;
    raw = p - n;
    sat = (raw < -LIM);
    v = sat ? -LIM : raw;
    preset_mag_i = MW'(p < 0 ? -p : p);
    preset_neg_i = (p < 0);
    gate_i = 1;
    tick();
    chk("R2 active after rise", active_o, 1);
    chk("R3 preset load", sval(live_neg_o, live_mag_o), p);
    chk("R6 zero cleared on rise", zero_o, 0);
    pulse_i = 1;
    tick(n);
    pulse_i = 0;
    chk("R3 live value", sval(live_neg_o, live_mag_o), v);
    chk("R4 sign bit", live_neg_o, v < 0);
    chk("R5 trig", trig_o, n > 0);
    chk("R6 zero flag", zero_o, (n > 0) && (v <= 0));
    chk("R7 live ovf", live_ovf_o, sat);
    chk("R11 irq ovf", irq_o, sat);
    gate_i = 0;
    tick();
    chk("R9 final value", sval(final_neg_o, final_mag_o), v);
    chk("R9 final oor", final_oor_o, sat);
    chk("R9 stored", stored_o, 1);
    chk("R2 active after fall", active_o, 0);
    if (sat) begin
      irq_rd_i = 1;
      tick();
      irq_rd_i = 0;
      chk("R8 ovf cleared by irq read", live_ovf_o, 0);
      chk("R11 irq cleared", irq_o, 0);
    end
    status_rd_i = 1; final_rd_i = 1;
    tick();
    status_rd_i = 0; final_rd_i = 0;
    chk("R5 trig cleared by status read", trig_o, 0);
    chk("R9 stored cleared", stored_o, 0);
    chk("R6 zero kept on status read", zero_o, (n > 0) && (v <= 0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 reset flags", {trig_o, zero_o, live_ovf_o, stored_o, overwrite_o, irq_o, active_o}, 0);
    chk("R1 reset values", {live_mag_o, live_neg_o, final_mag_o, final_neg_o, final_oor_o}, 0);
    rst_n = 1;
    tick();
    irq_ovf_en_i = 1;

    for (int p = -LIM; p <= LIM; p += 4)
      for (int n = 0; n <= 2 * LIM + 4; n++)
        run(p, n);

    // R3: clamp and negative zero normalisation
    preset_mag_i = MW'(31); preset_neg_i = 0; gate_i = 1;
    tick();
    chk("R3 clamp preset", sval(live_neg_o, live_mag_o), LIM);
    gate_i = 0; tick(); clear_all();
    preset_mag_i = '0; preset_neg_i = 1; gate_i = 1;
    tick();
    chk("R3 negative zero", live_neg_o, 0);
    // R3: pulses while gate low ignored
    preset_mag_i = MW'(7); preset_neg_i = 0;
    gate_i = 0; tick(); clear_all();
    gate_i = 1; tick(); gate_i = 0; tick();
    pulse_i = 1; tick(5); pulse_i = 0;
    chk("R3 gate low pulses ignored", sval(live_neg_o, live_mag_o), 7);
    chk("R5 no trig without gate", trig_o, 0);
    clear_all();

    // R11: overflow with interrupt disabled
    irq_ovf_en_i = 0;
    preset_mag_i = MW'(LIM); preset_neg_i = 1; gate_i = 1; tick();
    pulse_i = 1; tick(); pulse_i = 0;
    chk("R7 ovf flag at limit", live_ovf_o, 1);
    chk("R11 irq masked", irq_o, 0);
    irq_rd_i = 1; tick(); irq_rd_i = 0;
    chk("R8 irq read keeps ovf without irq", live_ovf_o, 1);
    status_rd_i = 1; tick(); status_rd_i = 0;
    chk("R8 status read clears ovf", live_ovf_o, 0);
    // R12: set wins against status read
    pulse_i = 1; status_rd_i = 1; tick(); pulse_i = 0; status_rd_i = 0;
    chk("R12 ovf set wins", live_ovf_o, 1);
    gate_i = 0; tick(); clear_all();

    // R10: overwrite and its interrupt
    irq_ovw_en_i = 1;
    preset_mag_i = MW'(3); preset_neg_i = 0;
    gate_i = 1; tick(); gate_i = 0; tick();
    chk("R10 first store no overwrite", overwrite_o, 0);
    gate_i = 1; tick(); gate_i = 0; status_rd_i = 1; tick(); status_rd_i = 0;
    chk("R10 overwrite set", overwrite_o, 1);
    chk("R12 stored set wins", stored_o, 1);
    chk("R11 irq ovw", irq_ovw_o, 1);
    irq_rd_i = 1; tick(); irq_rd_i = 0;
    chk("R11 irq ovw cleared", irq_o, 0);
    chk("R10 overwrite held past irq read", overwrite_o, 1);
    status_rd_i = 1; tick(); status_rd_i = 0;
    chk("R10 overwrite cleared", overwrite_o, 0);
    gate_i = 1; tick(); gate_i = 0; final_rd_i = 1; tick(); final_rd_i = 0;
    chk("R10 same-cycle final read", overwrite_o, 0);
    final_rd_i = 1; tick(); final_rd_i = 0;
    gate_i = 1; tick(); gate_i = 0; tick();
    chk("R10 read value not overwritten", overwrite_o, 0);
    chk("R11 no irq", irq_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule